// File: doc/BRIEF.md
# Dual-Side Inter-Processor Mailbox

This block joins two processors, called side A and side B, that each reach it through a small register bus of their own. Each side can post a 32-bit word into one of four outgoing message slots. The word then waits in the matching incoming slot of the other side until that side reads it. Per-slot status bits tell the writer when a slot may be written again and tell the reader when a word is waiting.

Each side also owns a 3-bit flag field that is carried over to the other side. A transfer takes two cycles, and a busy bit covers that window. Four general-purpose interrupt requests per direction are raised by one side and stay raised until the far side accepts them. Each side has a mask that selects which incoming requests drive its interrupt line.

The bus is a single-cycle strobe: `sel` with `wr` high is a write, and `sel` with `wr` low is a read. Read data is combinational from the address. Side effects of a read, such as emptying a slot, take place at the clock edge that ends the access. Registers per side (4-bit address): addresses 0 to 3 write outgoing slot n and read incoming slot n. Address 4 is status. Address 5 is control. All other addresses read zero and ignore writes.

Top module: `mbx_dual_top`

## Requirements
- R1: After reset, status (address 4) reads 0x0000000F on both sides, with every outgoing-empty bit set and nothing else. Control (address 5) reads 0 on both sides, and both interrupt lines are low.
- R2: A write to address n (0 to 3) while outgoing-empty bit n (status bit n) is set stores the word. From the next cycle, the writer's status bit n is clear and the far side's incoming-full bit n (status bit 4+n) is set.
- R3: A read of address n returns the word the far side last stored in slot n. If incoming-full bit n was set, the read clears that bit and sets the writer's outgoing-empty bit n, both from the next cycle.
- R4: A write to address n while outgoing-empty bit n is clear is ignored, and the stored word stays unchanged.
- R5: A write to address 5 while the busy bit (status bit 11) is clear captures bits 2:0 as the local flags. Control bits 2:0 read them back from the next cycle. The busy bit is set for exactly the two cycles after the write. In the cycle busy clears, the far side's status bits 10:8 show the new flags.
- R6: A write to the flag field while the busy bit is set has no effect on the local flags, the far flags or the busy window.
- R7: Writing 1 to control bit 4+g while request g is idle raises it. From the next cycle it reads as control bit 4+g on the raising side and as pending bit 12+g in the far side's status. Writing 0, or writing 1 while the request is already raised, has no effect.
- R8: Writing 1 to status bit 12+g on the receiving side clears pending g there and request g on the raising side from the next cycle. Zero bits have no effect. If an accept and a new raise land in the same cycle, the accept wins.
- R9: Control bits 11:8 hold a per-side interrupt mask, written by every control write. The side's interrupt line is high exactly when some pending bit and the matching mask bit are both set.
- R10: Addresses 6 to 15 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 4 | Side A register address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 1 | Interrupt line to processor A |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 4 | Side B register address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Interrupt line to processor B |

## Verification
The hardest cases to reach are the ones where both sides act on the same shared state in the same cycle. One is a write to a full slot that lands in the same cycle the far side reads it empty. Another is an accept and a re-raise of one interrupt in a single cycle. A third is a flag write that lands inside the two-cycle busy window. Directed sequences set up each of these on purpose. After that, a long run of seeded random traffic drives both buses at once on every cycle, so these collisions recur many times against a cycle-accurate model in the bench.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SLOT_EMPTY,
        SLOT_FULL
    } slot_state_e;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_SEND,
        FL_SETTLE
    } flag_state_e;

    typedef enum logic {
        GPI_IDLE,
        GPI_RAISED
    } gpi_state_e;

endpackage

// File: rtl/mbx_slot.sv
// One message channel: written by one side, read by the other.
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    slot_state_e       state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              load;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (wr_en) begin
                    state_d = SLOT_FULL;
                    load    = 1'b1;
                end
            end
            SLOT_FULL: begin
                if (rd_en) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) data_q <= wr_data;
        end
    end

    always_comb begin
        full = (state_q == SLOT_FULL);
        data = data_q;
    end

endmodule

// File: rtl/mbx_flag_link.sv
// Carries one side's flag field to the other side over a two-cycle window.
module mbx_flag_link
    import mbx_pkg::*;
#(
    parameter int FLAG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_val,
    output logic              busy,
    output logic [FLAG_W-1:0] local_val,
    output logic [FLAG_W-1:0] far_val
);

    flag_state_e       state_q, state_d;
    logic [FLAG_W-1:0] cap_q, mir_q;
    logic              capture, publish;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        publish = 1'b0;
        unique case (state_q)
            FL_IDLE: begin
                if (wr_en) begin
                    state_d = FL_SEND;
                    capture = 1'b1;
                end
            end
            FL_SEND:   state_d = FL_SETTLE;
            FL_SETTLE: begin
                state_d = FL_IDLE;
                publish = 1'b1;
            end
            default:   state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
            cap_q   <= '0;
            mir_q   <= '0;
        end else begin
            state_q <= state_d;
            if (capture) cap_q <= wr_val;
            if (publish) mir_q <= cap_q;
        end
    end

    always_comb begin
        busy      = (state_q != FL_IDLE);
        local_val = cap_q;
        far_val   = mir_q;
    end

endmodule

// File: rtl/mbx_gpi_line.sv
// One general-purpose interrupt request, raised on one side, accepted on the other.
module mbx_gpi_line
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic accept,
    output logic pending
);

    gpi_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GPI_IDLE:   if (raise)  state_d = GPI_RAISED;
            GPI_RAISED: if (accept) state_d = GPI_IDLE;
            default:    state_d = GPI_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GPI_IDLE;
        else        state_q <= state_d;
    end

    always_comb pending = (state_q == GPI_RAISED);

endmodule

// File: rtl/mbx_port.sv
// Register decode, read mux, mask and interrupt for one side.
module mbx_port #(
    parameter int DATA_W  = 32,
    parameter int NUM_MSG = 4,
    parameter int NUM_GPI = 4,
    parameter int FLAG_W  = 3,
    parameter int ADDR_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic [NUM_MSG-1:0]        tx_full,
    input  logic [NUM_MSG-1:0]        rx_full,
    input  logic [NUM_MSG*DATA_W-1:0] rx_data,
    input  logic                      flag_busy,
    input  logic [FLAG_W-1:0]         flag_local,
    input  logic [FLAG_W-1:0]         flag_far,
    input  logic [NUM_GPI-1:0]        gp_out,
    input  logic [NUM_GPI-1:0]        gp_in,
    output logic [NUM_MSG-1:0]        tx_wr,
    output logic [NUM_MSG-1:0]        rx_rd,
    output logic                      flag_wr,
    output logic [NUM_GPI-1:0]        gp_raise,
    output logic [NUM_GPI-1:0]        gp_accept,
    output logic [DATA_W-1:0]         rdata,
    output logic                      irq
);

    localparam int REG_STS     = NUM_MSG;
    localparam int REG_CTL     = NUM_MSG + 1;
    localparam int STS_RXF_LO  = NUM_MSG;
    localparam int STS_FLAG_LO = 2 * NUM_MSG;
    localparam int STS_BUSY    = STS_FLAG_LO + FLAG_W;
    localparam int STS_GP_LO   = STS_BUSY + 1;
    localparam int CTL_GP_LO   = FLAG_W + 1;
    localparam int CTL_MASK_LO = CTL_GP_LO + NUM_GPI;

    logic               wr_hit, rd_hit, is_sts, is_ctl;
    logic [NUM_GPI-1:0] mask_q;

    always_comb begin
        wr_hit = sel && wr;
        rd_hit = sel && !wr;
        is_sts = (addr == ADDR_W'(REG_STS));
        is_ctl = (addr == ADDR_W'(REG_CTL));
        flag_wr = wr_hit && is_ctl;
    end

    for (genvar n = 0; n < NUM_MSG; n++) begin : g_msg
        assign tx_wr[n] = wr_hit && (addr == ADDR_W'(n));
        assign rx_rd[n] = rd_hit && (addr == ADDR_W'(n));
    end

    for (genvar g = 0; g < NUM_GPI; g++) begin : g_gp
        assign gp_raise[g]  = wr_hit && is_ctl && wdata[CTL_GP_LO + g];
        assign gp_accept[g] = wr_hit && is_sts && wdata[STS_GP_LO + g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                mask_q <= '0;
        else if (wr_hit && is_ctl) mask_q <= wdata[CTL_MASK_LO +: NUM_GPI];
    end

    always_comb irq = |(gp_in & mask_q);

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_MSG; n++) begin
            if (addr == ADDR_W'(n)) rdata = rx_data[n*DATA_W +: DATA_W];
        end
        if (is_sts) begin
            rdata[NUM_MSG-1:0]                = ~tx_full;
            rdata[STS_RXF_LO +: NUM_MSG]      = rx_full;
            rdata[STS_FLAG_LO +: FLAG_W]      = flag_far;
            rdata[STS_BUSY]                   = flag_busy;
            rdata[STS_GP_LO +: NUM_GPI]       = gp_in;
        end
        if (is_ctl) begin
            rdata[FLAG_W-1:0]                 = flag_local;
            rdata[CTL_GP_LO +: NUM_GPI]       = gp_out;
            rdata[CTL_MASK_LO +: NUM_GPI]     = mask_q;
        end
    end

endmodule

// File: rtl/mbx_dual_top.sv
module mbx_dual_top #(
    parameter int DATA_W  = 32,
    parameter int NUM_MSG = 4,
    parameter int NUM_GPI = 4,
    parameter int FLAG_W  = 3,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    input  logic              b_sel,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq
);

    logic [NUM_MSG-1:0]        ab_full, ba_full;
    logic [NUM_MSG*DATA_W-1:0] ab_data, ba_data;
    logic [NUM_MSG-1:0]        a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
    logic                      a_flag_wr, b_flag_wr;
    logic                      a_fbusy, b_fbusy;
    logic [FLAG_W-1:0]         a_flocal, b_flocal;
    logic [FLAG_W-1:0]         ab_flags, ba_flags;
    logic [NUM_GPI-1:0]        ab_gp, ba_gp;
    logic [NUM_GPI-1:0]        a_raise, a_accept, b_raise, b_accept;

    for (genvar n = 0; n < NUM_MSG; n++) begin : g_slot
        mbx_slot #(.DATA_W(DATA_W)) u_ab (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (a_tx_wr[n]),
            .wr_data (a_wdata),
            .rd_en   (b_rx_rd[n]),
            .full    (ab_full[n]),
            .data    (ab_data[n*DATA_W +: DATA_W])
        );
        mbx_slot #(.DATA_W(DATA_W)) u_ba (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (b_tx_wr[n]),
            .wr_data (b_wdata),
            .rd_en   (a_rx_rd[n]),
            .full    (ba_full[n]),
            .data    (ba_data[n*DATA_W +: DATA_W])
        );
    end

    for (genvar g = 0; g < NUM_GPI; g++) begin : g_gpi
        mbx_gpi_line u_ab (
            .clk     (clk),
            .rst_n   (rst_n),
            .raise   (a_raise[g]),
            .accept  (b_accept[g]),
            .pending (ab_gp[g])
        );
        mbx_gpi_line u_ba (
            .clk     (clk),
            .rst_n   (rst_n),
            .raise   (b_raise[g]),
            .accept  (a_accept[g]),
            .pending (ba_gp[g])
        );
    end

    mbx_flag_link #(.FLAG_W(FLAG_W)) u_flag_ab (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (a_flag_wr),
        .wr_val    (a_wdata[FLAG_W-1:0]),
        .busy      (a_fbusy),
        .local_val (a_flocal),
        .far_val   (ab_flags)
    );

    mbx_flag_link #(.FLAG_W(FLAG_W)) u_flag_ba (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (b_flag_wr),
        .wr_val    (b_wdata[FLAG_W-1:0]),
        .busy      (b_fbusy),
        .local_val (b_flocal),
        .far_val   (ba_flags)
    );

    mbx_port #(
        .DATA_W(DATA_W), .NUM_MSG(NUM_MSG), .NUM_GPI(NUM_GPI),
        .FLAG_W(FLAG_W), .ADDR_W(ADDR_W)
    ) u_port_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (a_sel),
        .wr         (a_wr),
        .addr       (a_addr),
        .wdata      (a_wdata),
        .tx_full    (ab_full),
        .rx_full    (ba_full),
        .rx_data    (ba_data),
        .flag_busy  (a_fbusy),
        .flag_local (a_flocal),
        .flag_far   (ba_flags),
        .gp_out     (ab_gp),
        .gp_in      (ba_gp),
        .tx_wr      (a_tx_wr),
        .rx_rd      (a_rx_rd),
        .flag_wr    (a_flag_wr),
        .gp_raise   (a_raise),
        .gp_accept  (a_accept),
        .rdata      (a_rdata),
        .irq        (a_irq)
    );

    mbx_port #(
        .DATA_W(DATA_W), .NUM_MSG(NUM_MSG), .NUM_GPI(NUM_GPI),
        .FLAG_W(FLAG_W), .ADDR_W(ADDR_W)
    ) u_port_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (b_sel),
        .wr         (b_wr),
        .addr       (b_addr),
        .wdata      (b_wdata),
        .tx_full    (ba_full),
        .rx_full    (ab_full),
        .rx_data    (ab_data),
        .flag_busy  (b_fbusy),
        .flag_local (b_flocal),
        .flag_far   (ab_flags),
        .gp_out     (ba_gp),
        .gp_in      (ab_gp),
        .tx_wr      (b_tx_wr),
        .rx_rd      (b_rx_rd),
        .flag_wr    (b_flag_wr),
        .gp_raise   (b_raise),
        .gp_accept  (b_accept),
        .rdata      (b_rdata),
        .irq        (b_irq)
    );

endmodule

// File: rtl/mbx_dual_checker.sv
module mbx_dual_checker #(
    parameter int DATA_W  = 32,
    parameter int NUM_MSG = 4,
    parameter int NUM_GPI = 4,
    parameter int FLAG_W  = 3,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               a_sel,
    input logic               a_wr,
    input logic [ADDR_W-1:0]  a_addr,
    input logic [DATA_W-1:0]  a_wdata,
    input logic               b_sel,
    input logic               b_wr,
    input logic [ADDR_W-1:0]  b_addr,
    input logic [DATA_W-1:0]  b_wdata,
    input logic               a_irq,
    input logic               b_irq,
    input logic [NUM_MSG-1:0] ab_full,
    input logic [NUM_MSG-1:0] ba_full,
    input logic [NUM_GPI-1:0] ab_gp,
    input logic [NUM_GPI-1:0] ba_gp,
    input logic               a_fbusy,
    input logic               b_fbusy,
    input logic [FLAG_W-1:0]  ab_flags,
    input logic [FLAG_W-1:0]  ba_flags
);

    localparam int REG_STS   = NUM_MSG;
    localparam int REG_CTL   = NUM_MSG + 1;
    localparam int STS_GP_LO = 2 * NUM_MSG + FLAG_W + 1;
    localparam int CTL_GP_LO = FLAG_W + 1;

    for (genvar n = 0; n < NUM_MSG; n++) begin : g_msg
        a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
            (a_sel && a_wr && a_addr == ADDR_W'(n) && !ab_full[n]) |=> ab_full[n]);
        a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (ab_full[n] && !(b_sel && !b_wr && b_addr == ADDR_W'(n))) |=> ab_full[n]);
        a_r3_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (ba_full[n] && a_sel && !a_wr && a_addr == ADDR_W'(n)) |=> !ba_full[n]);
    end

    a_r5_busy_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_fbusy) |=> (a_fbusy ##1 !a_fbusy));
    a_r6_flags_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(b_fbusy) |-> $stable(ba_flags));

    for (genvar g = 0; g < NUM_GPI; g++) begin : g_gp
        a_r7_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (!ab_gp[g] && a_sel && a_wr && a_addr == ADDR_W'(REG_CTL) && a_wdata[CTL_GP_LO + g])
            |=> ab_gp[g]);
        a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ab_gp[g] && b_sel && b_wr && b_addr == ADDR_W'(REG_STS) && b_wdata[STS_GP_LO + g])
            |=> !ab_gp[g]);
    end

    a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        a_irq |-> (|ba_gp));
    a_r9_irq_b_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        b_irq |-> (|ab_gp));

endmodule

bind mbx_dual_top mbx_dual_checker u_chk (.*);

// File: tb/tb_mbx_dual_top.sv
`timescale 1ns/1ps
module tb_mbx_dual_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_sel = 1'b0, a_wr = 1'b0, b_sel = 1'b0, b_wr = 1'b0;
    logic [3:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    mbx_dual_top dut (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    // Reference model, index 0 = side A, 1 = side B; direction s means from side s.
    logic [3:0]  m_full [2];
    logic [31:0] m_data [2][4];
    int          m_fst  [2];
    logic [2:0]  m_fcap [2];
    logic [2:0]  m_fmir [2];
    logic [3:0]  m_gp   [2];
    logic [3:0]  m_mask [2];

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            m_full[s] = '0; m_fst[s] = 0; m_fcap[s] = '0; m_fmir[s] = '0;
            m_gp[s] = '0; m_mask[s] = '0;
            for (int n = 0; n < 4; n++) m_data[s][n] = '0;
        end
    endtask

    function automatic logic [31:0] exp_rdata(int s, logic [3:0] a);
        int o = 1 - s;
        logic [31:0] v = '0;
        if (a < 4) v = m_data[o][a];
        else if (a == 4) begin
            v[3:0] = ~m_full[s]; v[7:4] = m_full[o]; v[10:8] = m_fmir[o];
            v[11] = (m_fst[s] != 0); v[15:12] = m_gp[o];
        end else if (a == 5) begin
            v[2:0] = m_fcap[s]; v[7:4] = m_gp[s]; v[11:8] = m_mask[s];
        end
        return v;
    endfunction

    function automatic logic exp_irq(int s);
        return |(m_gp[1-s] & m_mask[s]);
    endfunction

    function automatic string tag_for(logic [3:0] a);
        if (a < 4) return "R3";
        if (a == 4) return "R2";
        if (a == 5) return "R7";
        return "R10";
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic model_step(logic sl[2], logic wl[2], logic [3:0] al[2], logic [31:0] dl[2]);
        logic [3:0]  nf [2];
        logic [31:0] nd [2][4];
        int          nst[2];
        logic [2:0]  ncap[2], nmir[2];
        logic [3:0]  ngp[2], nmask[2];
        for (int s = 0; s < 2; s++) begin
            nf[s] = m_full[s]; nst[s] = m_fst[s]; ncap[s] = m_fcap[s]; nmir[s] = m_fmir[s];
            ngp[s] = m_gp[s]; nmask[s] = m_mask[s];
            for (int n = 0; n < 4; n++) nd[s][n] = m_data[s][n];
        end
        for (int s = 0; s < 2; s++) begin
            int o = 1 - s;
            logic sw = sl[s] && wl[s];
            logic orr = sl[o] && !wl[o];
            logic ow = sl[o] && wl[o];
            for (int n = 0; n < 4; n++) begin
                if (m_full[s][n]) begin
                    if (orr && al[o] == 4'(n)) nf[s][n] = 1'b0;
                end else if (sw && al[s] == 4'(n)) begin
                    nf[s][n] = 1'b1; nd[s][n] = dl[s];
                end
            end
            if (m_fst[s] == 1) nst[s] = 2;
            else if (m_fst[s] == 2) begin nst[s] = 0; nmir[s] = m_fcap[s]; end
            else if (sw && al[s] == 4'd5) begin nst[s] = 1; ncap[s] = dl[s][2:0]; end
            for (int g = 0; g < 4; g++) begin
                if (m_gp[s][g]) begin
                    if (ow && al[o] == 4'd4 && dl[o][12+g]) ngp[s][g] = 1'b0;
                end else if (sw && al[s] == 4'd5 && dl[s][4+g]) ngp[s][g] = 1'b1;
            end
            if (sw && al[s] == 4'd5) nmask[s] = dl[s][11:8];
        end
        for (int s = 0; s < 2; s++) begin
            m_full[s] = nf[s]; m_fst[s] = nst[s]; m_fcap[s] = ncap[s]; m_fmir[s] = nmir[s];
            m_gp[s] = ngp[s]; m_mask[s] = nmask[s];
            for (int n = 0; n < 4; n++) m_data[s][n] = nd[s][n];
        end
    endtask

    // One bus cycle on both sides; reads and interrupt lines are compared with the model.
    task automatic cyc(logic as, logic aw, logic [3:0] aa, logic [31:0] ad,
                       logic bs, logic bw, logic [3:0] ba, logic [31:0] bd, string tag);
        logic sl[2], wl[2];
        logic [3:0] al[2];
        logic [31:0] dl[2];
        @(negedge clk);
        a_sel = as; a_wr = aw; a_addr = aa; a_wdata = ad;
        b_sel = bs; b_wr = bw; b_addr = ba; b_wdata = bd;
        #1;
        if (as && !aw) check(tag != "" ? tag : tag_for(aa), a_rdata, exp_rdata(0, aa));
        if (bs && !bw) check(tag != "" ? tag : tag_for(ba), b_rdata, exp_rdata(1, ba));
        check("R9", {31'd0, a_irq}, {31'd0, exp_irq(0)});
        check("R9", {31'd0, b_irq}, {31'd0, exp_irq(1)});
        sl[0] = as; wl[0] = aw; al[0] = aa; dl[0] = ad;
        sl[1] = bs; wl[1] = bw; al[1] = ba; dl[1] = bd;
        model_step(sl, wl, al, dl);
    endtask

    task automatic idle(string tag);
        cyc(1'b0, 1'b0, 4'd0, 32'd0, 1'b0, 1'b0, 4'd0, 32'd0, tag);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of both sides
        cyc(1, 0, 4'd4, 0, 1, 0, 4'd4, 0, "R1");
        cyc(1, 0, 4'd5, 0, 1, 0, 4'd5, 0, "R1");

        // R2: A posts to slot 1, both status registers observe it
        cyc(1, 1, 4'd1, 32'hCAFE_0001, 0, 0, 0, 0, "R2");
        cyc(1, 0, 4'd4, 0, 1, 0, 4'd4, 0, "R2");
        // R3: B reads slot 1, full clears, A's empty returns
        cyc(0, 0, 0, 0, 1, 0, 4'd1, 0, "R3");
        cyc(1, 0, 4'd4, 0, 1, 0, 4'd4, 0, "R3");
        // R4: second write to a full slot is dropped
        cyc(0, 0, 0, 0, 1, 1, 4'd2, 32'h1111_2222, "R4");
        cyc(0, 0, 0, 0, 1, 1, 4'd2, 32'h3333_4444, "R4");
        cyc(1, 0, 4'd2, 0, 0, 0, 0, 0, "R4");
        // R4: write to full slot in the same cycle the far side empties it
        cyc(1, 1, 4'd0, 32'hAAAA_0000, 0, 0, 0, 0, "R4");
        cyc(1, 1, 4'd0, 32'hBBBB_0000, 1, 0, 4'd0, 0, "R4");
        cyc(1, 0, 4'd4, 0, 1, 0, 4'd0, 0, "R4");

        // R5: flag transfer window
        cyc(1, 1, 4'd5, 32'h0000_0005, 1, 0, 4'd4, 0, "R5");
        cyc(1, 0, 4'd4, 0, 1, 0, 4'd4, 0, "R5");
        // R6: write inside the busy window
        cyc(1, 1, 4'd5, 32'h0000_0002, 1, 0, 4'd4, 0, "R6");
        cyc(1, 0, 4'd4, 0, 1, 0, 4'd4, 0, "R6");
        cyc(1, 0, 4'd5, 0, 1, 0, 4'd4, 0, "R6");

        // R7: raise requests 0 and 2, then re-raise 0 and write zeros
        cyc(1, 1, 4'd5, 32'h0000_0050, 0, 0, 0, 0, "R7");
        cyc(1, 0, 4'd5, 0, 1, 0, 4'd4, 0, "R7");
        cyc(1, 1, 4'd5, 32'h0000_0010, 0, 0, 0, 0, "R7");
        cyc(1, 0, 4'd5, 0, 1, 0, 4'd4, 0, "R7");
        // R9: B unmasks request 2 only
        cyc(0, 0, 0, 0, 1, 1, 4'd5, 32'h0000_0400, "R9");
        idle("R9");
        // R8: B accepts request 2 while A re-raises it in the same cycle
        cyc(1, 1, 4'd5, 32'h0000_0040, 1, 1, 4'd4, 32'h0000_4000, "R8");
        cyc(1, 0, 4'd5, 0, 1, 0, 4'd4, 0, "R8");
        cyc(0, 0, 0, 0, 1, 1, 4'd4, 32'h0000_0000, "R8");
        cyc(1, 0, 4'd5, 0, 1, 0, 4'd4, 0, "R8");

        // R10: unused addresses
        cyc(1, 1, 4'd6, 32'hFFFF_FFFF, 1, 1, 4'd15, 32'hFFFF_FFFF, "R10");
        cyc(1, 0, 4'd7, 0, 1, 0, 4'd9, 0, "R10");
        cyc(1, 0, 4'd4, 0, 1, 0, 4'd5, 0, "R10");

        // Seeded random traffic on both buses
        for (int i = 0; i < 4000; i++) begin
            logic as = ($urandom % 4) != 0;
            logic bs = ($urandom % 4) != 0;
            logic aw = $urandom % 2;
            logic bw = $urandom % 2;
            logic [3:0] aa = 4'($urandom % 8);
            logic [3:0] ba = 4'($urandom % 8);
            cyc(as, aw, aa, $urandom, bs, bw, ba, $urandom, "");
        end

        // Final status snapshot
        cyc(1, 0, 4'd4, 0, 1, 0, 4'd4, 0, "R2");
        cyc(1, 0, 4'd5, 0, 1, 0, 4'd5, 0, "R7");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule